// File: doc/BRIEF.md
# Mode-Switched Address / General I/O Port

This block controls one 8-pin port of a microcontroller. Depending on a 3-bit operating-mode input, each pin carries one bit of the upper address byte, acts as a plain input, or works as a general-purpose I/O bit. Software programs three registers over a small register bus: an output-data register, a direction register and a pull-up enable register. For every pin the block produces the driven value, the output enable, the pull-up enable, and the value that a read of the data register returns.

In the fully expanded modes the whole port is the address byte. In the mixed modes each direction bit chooses between an address line and an input. In single-chip mode the port is ordinary I/O. When the current access targets the DRAM-mapped area, the two lowest address pins carry the multiplexed row/column address bits instead of the plain address. The mode input is registered, so a mode change is seen one clock edge later.

Top module: `modal_port`

## Requirements
- R1: In the address function, pin k outputs bit k of `addr_hi_i` (pin 7 carries the top address bit, pin 0 the lowest bit of the byte).
- R2: With registered mode 1, 2, 3 or 4, all pins have output enable 1 and drive the address, whatever the direction register holds.
- R3: With registered mode 5 or 6, a pin whose direction bit is 1 drives its address bit with enable 1; a pin whose direction bit is 0 is an input with enable 0 and driven value 0.
- R4: With registered mode 7, or the reserved mode 0, a pin whose direction bit is 1 drives its data-register bit with enable 1; a direction bit of 0 makes it an input with enable 0 and driven value 0.
- R5: When `dram_area_i` is 1, pins 1 and 0 in the address function drive `dram_mux_i[1]` and `dram_mux_i[0]` instead of the address; pins 7 to 2 and pins in any other function are unaffected.
- R6: A pin's pull-up output is 1 only when its pull-up register bit is 1 and its output enable is 0.
- R7: In every mode, bit k of a data-register read is the data-register bit when pin k's output enable is 1 and `pin_in_i[k]` when it is 0.
- R8: A data-register write made in an address mode is stored (visible on readback and on the pins once in mode 7) but does not change the pins while the address function holds.
- R9: The mode input is captured at a clock edge; pin behaviour follows the new mode only after that edge.
- R10: Synchronous reset clears the data, direction and pull-up registers and sets the registered mode to 0, so after reset every pin is an input with no pull-up.
- R11: Register select 0 is data, 1 is direction, 2 is pull-up; a write lands at the next clock edge; select 3 reads as 0 and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode, captured each edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 data, 1 direction, 2 pull-up) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| addr_hi_i | input | 8 | Upper address byte of the current access |
| dram_area_i | input | 1 | Current access targets the DRAM area |
| dram_mux_i | input | 2 | Row/column multiplexed address bits |
| pin_in_i | input | 8 | Levels sampled at the pins |
| pin_out_o | output | 8 | Value driven on each pin |
| pin_oe_o | output | 8 | Output enable per pin |
| pin_pu_o | output | 8 | Pull-up enable per pin |

## Verification
The bench targets the mode boundaries: modes 4 versus 5, reserved mode 0 against mode 7, and the one-edge lag of a mode change, where a combinational mode path would switch pins a cycle early. It writes the data register while the port carries address, so a design that let the write reach the pins, or dropped it, is caught. DRAM substitution is checked both on address pins and on pins that are inputs or GPIO, where a leak would corrupt the value. Pull-ups are watched on driving pins, where leaving them on would fight the output.

// File: rtl/modal_port_pkg.sv
package modal_port_pkg;

    localparam int PORT_W = 8;
    localparam int MUX_W  = 2;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MC_GPIO        = 2'd0,
        MC_ADDR_FIXED  = 2'd1,
        MC_ADDR_SELECT = 2'd2
    } mode_class_e;

    typedef enum logic [1:0] {
        FN_INPUT    = 2'd0,
        FN_GPIO_OUT = 2'd1,
        FN_ADDR_OUT = 2'd2
    } pin_fn_e;

    typedef struct packed {
        logic drive;
        logic value;
        logic pull;
        logic rd;
    } pin_ctl_t;

    function automatic mode_class_e classify_mode(input logic [MODE_W-1:0] m);
        mode_class_e c;
        case (m)
            3'd1, 3'd2, 3'd3, 3'd4: c = MC_ADDR_FIXED;
            3'd5, 3'd6:             c = MC_ADDR_SELECT;
            default:                c = MC_GPIO;
        endcase
        return c;
    endfunction

    function automatic pin_fn_e pin_function(input mode_class_e c, input logic dir);
        pin_fn_e f;
        case (c)
            MC_ADDR_FIXED:  f = FN_ADDR_OUT;
            MC_ADDR_SELECT: f = dir ? FN_ADDR_OUT : FN_INPUT;
            default:        f = dir ? FN_GPIO_OUT : FN_INPUT;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/modal_port_regs.sv
module modal_port_regs
    import modal_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
        end else if (wr_i) begin
            case (sel)
                SEL_DATA: data_q <= wdata_i;
                SEL_DIR:  dir_q  <= wdata_i;
                SEL_PULL: pull_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    // R8 / R11: a data write is always stored
    p_data_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_DATA) |=> (data_q == $past(wdata_i)));

    // R11: writes to the unused select leave every register alone
    p_none_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_NONE) |=> ($stable(data_q) && $stable(dir_q) && $stable(pull_q)));

endmodule

// File: rtl/modal_port_pinmux.sv
module modal_port_pinmux
    import modal_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int MW = MUX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_class_e   cls_i,
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  dir_i,
    input  logic [W-1:0]  pull_i,
    input  logic [W-1:0]  addr_i,
    input  logic          dram_area_i,
    input  logic [MW-1:0] dram_mux_i,
    input  logic [W-1:0]  pin_in_i,
    output logic [W-1:0]  pin_out_o,
    output logic [W-1:0]  pin_oe_o,
    output logic [W-1:0]  pin_pu_o,
    output logic [W-1:0]  data_rd_o
);

    for (genvar k = 0; k < W; k++) begin : g_pin
        pin_fn_e  fn;
        logic     addr_bit;
        pin_ctl_t ctl;

        if (k < MW) begin : g_muxed
            assign addr_bit = dram_area_i ? dram_mux_i[k] : addr_i[k];
        end else begin : g_plain
            assign addr_bit = addr_i[k];
        end

        always_comb begin
            fn  = pin_function(cls_i, dir_i[k]);
            ctl = '0;
            case (fn)
                FN_ADDR_OUT: begin
                    ctl.drive = 1'b1;
                    ctl.value = addr_bit;
                end
                FN_GPIO_OUT: begin
                    ctl.drive = 1'b1;
                    ctl.value = data_i[k];
                end
                default: begin
                    ctl.drive = 1'b0;
                    ctl.value = 1'b0;
                end
            endcase
            ctl.pull = pull_i[k] & ~ctl.drive;
            ctl.rd   = ctl.drive ? data_i[k] : pin_in_i[k];
        end

        assign pin_out_o[k] = ctl.value;
        assign pin_oe_o[k]  = ctl.drive;
        assign pin_pu_o[k]  = ctl.pull;
        assign data_rd_o[k] = ctl.rd;

        // R6: pull-up never on a driving pin
        p_pull_off_drive_r6: assert property (@(posedge clk) disable iff (rst)
            !(pin_pu_o[k] && pin_oe_o[k]));

        // R3 / R4: an undriven pin outputs 0
        p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
            !pin_oe_o[k] |-> !pin_out_o[k]);
    end

    // R2: fixed address modes drive every pin
    p_fixed_all_out_r2: assert property (@(posedge clk) disable iff (rst)
        (cls_i == MC_ADDR_FIXED) |-> (pin_oe_o == '1));

    // R5: DRAM substitution on the low pins in fixed address modes
    p_dram_subst_r5: assert property (@(posedge clk) disable iff (rst)
        (cls_i == MC_ADDR_FIXED && dram_area_i) |-> (pin_out_o[MW-1:0] == dram_mux_i));

endmodule

// File: rtl/modal_port.sv
module modal_port
    import modal_port_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int MW     = MUX_W,
    parameter int MODE_B = MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_B-1:0] mode_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [W-1:0]      reg_wdata_i,
    output logic [W-1:0]      reg_rdata_o,
    input  logic [W-1:0]      addr_hi_i,
    input  logic              dram_area_i,
    input  logic [MW-1:0]     dram_mux_i,
    input  logic [W-1:0]      pin_in_i,
    output logic [W-1:0]      pin_out_o,
    output logic [W-1:0]      pin_oe_o,
    output logic [W-1:0]      pin_pu_o
);

    logic [MODE_B-1:0] mode_q;
    mode_class_e       cls;
    logic [W-1:0]      data_q, dir_q, pull_q, data_rd;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_i;
    end

    assign cls = classify_mode(mode_q);

    modal_port_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pull_q  (pull_q)
    );

    modal_port_pinmux #(.W(W), .MW(MW)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .cls_i       (cls),
        .data_i      (data_q),
        .dir_i       (dir_q),
        .pull_i      (pull_q),
        .addr_i      (addr_hi_i),
        .dram_area_i (dram_area_i),
        .dram_mux_i  (dram_mux_i),
        .pin_in_i    (pin_in_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o),
        .pin_pu_o    (pin_pu_o),
        .data_rd_o   (data_rd)
    );

    always_comb begin
        case (reg_sel_e'(reg_sel_i))
            SEL_DATA: reg_rdata_o = data_rd;
            SEL_DIR:  reg_rdata_o = dir_q;
            SEL_PULL: reg_rdata_o = pull_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    // R9: a fixed address mode presented now rules the pins after the edge
    p_mode_next_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_i inside {3'd1, 3'd2, 3'd3, 3'd4}) |=> (pin_oe_o == '1));

    // R11: the unused select reads zero
    p_none_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel_i == 2'd3) |-> (reg_rdata_o == '0));

endmodule

// File: tb/tb_modal_port.sv
module tb_modal_port;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode_i;
    logic       reg_wr_i;
    logic [1:0] reg_sel_i;
    logic [7:0] reg_wdata_i, reg_rdata_o;
    logic [7:0] addr_hi_i;
    logic       dram_area_i;
    logic [1:0] dram_mux_i;
    logic [7:0] pin_in_i, pin_out_o, pin_oe_o, pin_pu_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2:0] m_mode;
    logic [7:0] m_data, m_dir, m_pull;

    always #(CLK_P/2) clk = ~clk;

    modal_port dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .addr_hi_i(addr_hi_i), .dram_area_i(dram_area_i), .dram_mux_i(dram_mux_i),
        .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o)
    );

    // 0 gpio, 1 fixed address, 2 selectable address
    function automatic int mclass(input logic [2:0] m);
        if (m >= 3'd1 && m <= 3'd4) return 1;
        if (m == 3'd5 || m == 3'd6) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] exp_oe();
        return (mclass(m_mode) == 1) ? 8'hFF : m_dir;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] a, o;
        a = dram_area_i ? {addr_hi_i[7:2], dram_mux_i} : addr_hi_i;
        case (mclass(m_mode))
            1:       o = a;
            2:       o = a & m_dir;
            default: o = m_data & m_dir;
        endcase
        return o;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0] oe;
        oe = exp_oe();
        case (reg_sel_i)
            2'd0:    return (m_data & oe) | (pin_in_i & ~oe);
            2'd1:    return m_dir;
            2'd2:    return m_pull;
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h (mode %0d)", tag, act, exp, m_mode);
        end
    endtask

    task automatic check_all();
        string t;
        case (mclass(m_mode))
            1:       t = "R2 oe/out";
            2:       t = "R3 oe/out";
            default: t = "R4 oe/out";
        endcase
        cmp(t, pin_oe_o, exp_oe());
        cmp(t, pin_out_o, exp_out());
        cmp("R6 pull-up", pin_pu_o, m_pull & ~exp_oe());
        cmp((reg_sel_i == 2'd0) ? "R7 data read" : "R11 reg read", reg_rdata_o, exp_rd());
    endtask

    // one clock: inputs already set at negedge, update model at posedge, then check
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_mode = 3'd0; m_data = 8'h00; m_dir = 8'h00; m_pull = 8'h00;
        end else begin
            m_mode = mode_i;
            if (reg_wr_i) begin
                case (reg_sel_i)
                    2'd0: m_data = reg_wdata_i;
                    2'd1: m_dir  = reg_wdata_i;
                    2'd2: m_pull = reg_wdata_i;
                    default: ;
                endcase
            end
        end
        #2;
        check_all();
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [7:0] v);
        reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = v;
        step();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_mode = 0; m_data = 0; m_dir = 0; m_pull = 0;
        rst = 1'b1; mode_i = 3'd0; reg_wr_i = 1'b0; reg_sel_i = 2'd0; reg_wdata_i = 8'h00;
        addr_hi_i = 8'h00; dram_area_i = 1'b0; dram_mux_i = 2'b00; pin_in_i = 8'h00;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();
        // R10: after reset all inputs, nothing driven, registers zero
        cmp("R10 oe", pin_oe_o, 8'h00);
        cmp("R10 pu", pin_pu_o, 8'h00);
        reg_sel_i = 2'd1; #1 cmp("R10 dir", reg_rdata_o, 8'h00);
        reg_sel_i = 2'd2; #1 cmp("R10 pull", reg_rdata_o, 8'h00);
        reg_sel_i = 2'd0;

        // R1 / R2: walking one in mode 1 with direction cleared
        mode_i = 3'd1; step();
        for (int k = 0; k < 8; k++) begin
            addr_hi_i = 8'h01 << k; #1;
            cmp("R1 pin map", pin_out_o, 8'h01 << k);
            cmp("R2 oe", pin_oe_o, 8'hFF);
        end

        // R8: data write in address mode stored, pins unchanged
        mode_i = 3'd2; addr_hi_i = 8'h3C;
        wreg(2'd0, 8'hA5);
        cmp("R8 pins keep addr", pin_out_o, 8'h3C);
        reg_sel_i = 2'd0; #1 cmp("R8 stored", reg_rdata_o, 8'hA5);
        wreg(2'd1, 8'hFF);
        mode_i = 3'd7; step();
        cmp("R8 data reaches pins in mode 7", pin_out_o, 8'hA5);

        // R5: DRAM substitution, mode 5 with pins 1:0 address, rest input
        mode_i = 3'd5; wreg(2'd1, 8'h03);
        addr_hi_i = 8'hFF; dram_area_i = 1'b1; dram_mux_i = 2'b10; #1;
        cmp("R5 mixed", pin_out_o, 8'h02);
        mode_i = 3'd3; step();
        cmp("R5 fixed", pin_out_o, 8'hFE);
        mode_i = 3'd7; wreg(2'd0, 8'h00); #1;
        cmp("R5 no subst in gpio", pin_out_o, 8'h00);
        dram_area_i = 1'b0;

        // R9: mode change lags one edge
        wreg(2'd1, 8'h00);
        mode_i = 3'd1; #1;
        cmp("R9 before edge", pin_oe_o, 8'h00);
        step();
        cmp("R9 after edge", pin_oe_o, 8'hFF);
        // R4: reserved mode 0 acts as mode 7
        mode_i = 3'd0; wreg(2'd1, 8'h0F);
        wreg(2'd0, 8'h5A);
        cmp("R4 mode0 oe", pin_oe_o, 8'h0F);
        cmp("R4 mode0 out", pin_out_o, 8'h0A);

        // R11: select 3 write ignored, reads 0
        wreg(2'd3, 8'hFF);
        reg_sel_i = 2'd1; #1 cmp("R11 dir kept", reg_rdata_o, 8'h0F);
        reg_sel_i = 2'd0; pin_in_i = 8'h00; #1 cmp("R11 data kept", reg_rdata_o, 8'h0A);
        reg_sel_i = 2'd3; #1 cmp("R11 sel3 zero", reg_rdata_o, 8'h00);

        // R6: pull-ups only on inputs
        wreg(2'd2, 8'hFF);
        cmp("R6 pull on inputs", pin_pu_o, 8'hF0);

        // random mix, every cycle checked against the model
        for (int i = 0; i < 600; i++) begin
            mode_i      = 3'($urandom_range(0, 7));
            reg_wr_i    = ($urandom_range(0, 2) == 0);
            reg_sel_i   = 2'($urandom_range(0, 3));
            reg_wdata_i = 8'($urandom);
            addr_hi_i   = 8'($urandom);
            dram_area_i = 1'($urandom);
            dram_mux_i  = 2'($urandom);
            pin_in_i    = 8'($urandom);
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule